// File: doc/BRIEF.md
# Residue-Checked Integer Arithmetic Unit

This block pairs a 32-bit integer arithmetic unit with a separate checker. The unit adds, subtracts or multiplies two unsigned operands and produces a double-width result. The checker watches only the two operands, the operation code and the delivered result. It reduces each of them modulo a small check constant, combines the operand residues with the same operation modulo that constant, and compares the outcome with the residue of the delivered result. A mismatch raises a registered error flag one cycle later.

The checker never reads any node inside the arithmetic unit, so it adds no delay to the main datapath. A single residue datapath covers all three operations. Residues come from a chain of small modular adders over the bits of each value, weighted by powers of two modulo the constant, so no divider is needed. A fault-injection mask is XORed onto the unit's result before the result leaves the block and before the checker sees it. This lets a test corrupt the result on purpose.

Top module: `res_chk_top`

## Requirements
- R1: With op = 2'b00, `result` equals opa + opb, zero-extended to 64 bits, XORed with `flip_mask`.
- R2: With op = 2'b01, `result` equals opa − opb as a 64-bit two's-complement value, XORed with `flip_mask`.
- R3: With op = 2'b10, `result` equals the full 64-bit unsigned product opa × opb, XORed with `flip_mask`.
- R4: op = 2'b11 is reserved. `result` equals `flip_mask` (the unit outputs zero), and `chk_err` is never raised for it.
- R5: `chk_vld` is high in the cycle after a rising clock edge that sampled `in_vld` high, and low otherwise.
- R6: When `chk_vld` is high, `chk_err` is 1 exactly when the residue modulo A (default 3) of the delivered result differs from the operand residues combined by the sampled operation and reduced modulo A. The result is read as unsigned for op 00 and 10, and as signed for op 01. With a zero mask, no error is ever raised.
- R7: With A = 3, any single-bit `flip_mask` on op 00, 01 or 10 raises `chk_err`.
- R8: `chk_err` is low whenever `chk_vld` is low.
- R9: While `rst_n` is low, `chk_vld` and `chk_err` are both 0.
- R10: A corruption whose value change is a multiple of A goes undetected. For example, 4 + 0 with mask 64'h3 delivers 7, and `chk_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands and operation are valid this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 multiply, 11 reserved |
| opa | input | 32 | First operand (unsigned) |
| opb | input | 32 | Second operand (unsigned) |
| flip_mask | input | 64 | Fault-injection mask XORed onto the unit result |
| result | output | 64 | Delivered (possibly corrupted) result, combinational |
| chk_vld | output | 1 | Check outcome valid, one cycle after `in_vld` |
| chk_err | output | 1 | Residue mismatch detected |

## Verification
Two things can land in the same cycle. One is the registered flag for the previous operation. The other is the combinational result of a new, different operation, which may carry a different mask and a different signedness of residue interpretation. The bench provokes this with a continuous random stream: valid is high most cycles, and operation codes, corner operands and masks (none, single bit, or random) are mixed. At each falling edge it judges the flag against the expectation it computed for the previous cycle's operands. It judges the new result against a freshly computed reference, with both computed by independent modulo arithmetic in the bench.

// File: rtl/res_chk_pkg.sv
package res_chk_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  // 2^n mod m, evaluated at elaboration for fold weights and wrap offsets
  function automatic int unsigned pow2_mod(int unsigned n, int unsigned m);
    int unsigned p;
    p = 1 % m;
    for (int unsigned k = 0; k < n; k++) begin
      p = (p * 2) % m;
    end
    return p;
  endfunction

endpackage

// File: rtl/res_fold.sv
module res_fold
  import res_chk_pkg::*;
#(
  parameter int unsigned IN_W = 32,
  parameter int unsigned MODV = 3,
  parameter int unsigned RW   = 2
) (
  input  logic [IN_W-1:0] val_i,
  output logic [RW-1:0]   rsd_o
);

  localparam int unsigned   SW    = RW + 1;
  localparam logic [SW-1:0] MOD_S = SW'(MODV);

  // chain of modular adders: each stage adds the bit's weight 2^i mod MODV
  for (genvar i = 0; i < int'(IN_W); i++) begin : g_bit
    localparam logic [RW-1:0] WT = RW'(pow2_mod(i, MODV));
    logic [RW-1:0] acc_in;
    logic [SW-1:0] sum;
    logic [RW-1:0] acc_out;

    if (i == 0) begin : g_first
      assign acc_in = '0;
    end else begin : g_next
      assign acc_in = g_bit[i-1].acc_out;
    end

    assign sum     = {1'b0, acc_in} + (val_i[i] ? {1'b0, WT} : {SW{1'b0}});
    assign acc_out = (sum >= MOD_S) ? RW'(sum - MOD_S) : RW'(sum);
  end

  assign rsd_o = g_bit[IN_W-1].acc_out;

endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import res_chk_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  op_e             op_i,
  input  logic [W-1:0]    opa_i,
  input  logic [W-1:0]    opb_i,
  output logic [2*W-1:0]  res_o
);

  localparam int unsigned RES_W = 2 * W;

  logic [RES_W-1:0] a_ext;
  logic [RES_W-1:0] b_ext;

  assign a_ext = RES_W'(opa_i);
  assign b_ext = RES_W'(opb_i);

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_ext + b_ext;
      OP_SUB:  res_o = a_ext - b_ext;
      OP_MUL:  res_o = a_ext * b_ext;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/res_checker.sv
module res_checker
  import res_chk_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned A = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vld_i,
  input  op_e            op_i,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  input  logic [2*W-1:0] res_i,
  output logic           vld_o,
  output logic           err_o
);

  localparam int unsigned RES_W  = 2 * W;
  localparam int unsigned RW     = (A <= 2) ? 1 : $clog2(A);
  localparam int unsigned K_WRAP = pow2_mod(RES_W, A);
  localparam logic [RW:0] A_S    = (RW+1)'(A);
  localparam logic [RW:0] ADJ    = (RW+1)'((A - K_WRAP) % A);

  function automatic logic [RW-1:0] mred(logic [RW:0] s);
    return (s >= A_S) ? RW'(s - A_S) : RW'(s);
  endfunction

  logic [RW-1:0]   ra, rb, rr, rm;
  logic [2*RW-1:0] prod;
  logic [RW-1:0]   add_r, sub_r, rr_sgn;
  logic [RW-1:0]   exp_r, act_r;
  logic            chk_en;
  logic            err_d, vld_d;
  logic            err_q, vld_q;

  res_fold #(.IN_W(W),     .MODV(A), .RW(RW)) u_fold_a (.val_i(opa_i), .rsd_o(ra));
  res_fold #(.IN_W(W),     .MODV(A), .RW(RW)) u_fold_b (.val_i(opb_i), .rsd_o(rb));
  res_fold #(.IN_W(RES_W), .MODV(A), .RW(RW)) u_fold_r (.val_i(res_i), .rsd_o(rr));

  assign prod = (2*RW)'(ra) * (2*RW)'(rb);
  res_fold #(.IN_W(2*RW),  .MODV(A), .RW(RW)) u_fold_m (.val_i(prod), .rsd_o(rm));

  // next-state logic
  always_comb begin
    add_r  = mred({1'b0, ra} + {1'b0, rb});
    sub_r  = mred({1'b0, ra} + (A_S - {1'b0, rb}));
    rr_sgn = res_i[RES_W-1] ? mred({1'b0, rr} + ADJ) : rr;
    chk_en = 1'b1;
    unique case (op_i)
      OP_ADD: begin exp_r = add_r; act_r = rr;     end
      OP_SUB: begin exp_r = sub_r; act_r = rr_sgn; end
      OP_MUL: begin exp_r = rm;    act_r = rr;     end
      default: begin
        exp_r  = '0;
        act_r  = '0;
        chk_en = 1'b0;
      end
    endcase
    vld_d = vld_i;
    err_d = vld_i & chk_en & (exp_r != act_r);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign vld_o = vld_q;
  assign err_o = err_q;

  AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rr} < A_S) && ({1'b0, rm} < A_S)); // R6

endmodule

// File: rtl/res_chk_top.sv
module res_chk_top
  import res_chk_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned A = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [1:0]     op,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [2*W-1:0] flip_mask,
  output logic [2*W-1:0] result,
  output logic           chk_vld,
  output logic           chk_err
);

  localparam int unsigned RES_W = 2 * W;

  op_e              op_s;
  logic [RES_W-1:0] res_raw;

  assign op_s = op_e'(op);

  arith_unit #(.W(W)) u_arith (
    .op_i  (op_s),
    .opa_i (opa),
    .opb_i (opb),
    .res_o (res_raw)
  );

  assign result = res_raw ^ flip_mask;

  res_checker #(.W(W), .A(A)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_vld),
    .op_i  (op_s),
    .opa_i (opa),
    .opb_i (opb),
    .res_i (result),
    .vld_o (chk_vld),
    .err_o (chk_err)
  );

  AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> chk_vld); // R5
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !chk_vld); // R5
  AST_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> chk_vld); // R8
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && flip_mask == '0) |=> !chk_err); // R6
  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op == 2'b11) |=> !chk_err); // R4

endmodule

// File: tb/res_chk_top_tb.sv
module res_chk_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int A = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [1:0]  op;
  logic [31:0] opa, opb;
  logic [63:0] flip_mask;
  logic [63:0] result;
  logic        chk_vld, chk_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  res_chk_top #(.W(W), .A(A)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .opa(opa), .opb(opb),
    .flip_mask(flip_mask), .result(result), .chk_vld(chk_vld), .chk_err(chk_err)
  );

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 0;
  logic  p_vld = 1'b0;
  logic  p_exp = 1'b0;
  string p_tag = "R6";

  function automatic longint unsigned umod(logic [63:0] v);
    longint unsigned p32, hi, lo;
    p32 = 64'h1_0000_0000 % A;
    hi  = {32'b0, v[63:32]} % A;
    lo  = {32'b0, v[31:0]} % A;
    return (hi * p32 + lo) % A;
  endfunction

  function automatic longint unsigned resid(logic [63:0] v, bit sgn);
    longint unsigned r, p32, p64;
    p32 = 64'h1_0000_0000 % A;
    p64 = (p32 * p32) % A;
    r   = umod(v);
    if (sgn && v[63]) r = (r + A - p64) % A;
    return r;
  endfunction

  function automatic logic [63:0] ref_res(logic [1:0] o, logic [31:0] a, logic [31:0] b);
    case (o)
      2'b00:   return {32'b0, a} + {32'b0, b};
      2'b01:   return {32'b0, a} - {32'b0, b};
      2'b10:   return {32'b0, a} * {32'b0, b};
      default: return 64'b0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(bit vld, logic [1:0] o, logic [31:0] a, logic [31:0] b,
                       logic [63:0] m, string etag);
    logic [63:0] good, dlv;
    string rtag;
    @(negedge clk);
    check(chk_vld === p_vld, "R5", {63'b0, chk_vld}, {63'b0, p_vld});
    if (p_vld) check(chk_err === p_exp, p_tag, {63'b0, chk_err}, {63'b0, p_exp});
    else       check(chk_err === 1'b0, "R8", {63'b0, chk_err}, 64'b0);
    in_vld = vld; op = o; opa = a; opb = b; flip_mask = m;
    #1;
    good = ref_res(o, a, b);
    dlv  = good ^ m;
    case (o)
      2'b00:   rtag = "R1";
      2'b01:   rtag = "R2";
      2'b10:   rtag = "R3";
      default: rtag = "R4";
    endcase
    check(result === dlv, rtag, result, dlv);
    p_vld = vld;
    p_exp = (o == 2'b11) ? 1'b0 : (resid(dlv, o == 2'b01) != resid(good, o == 2'b01));
    p_tag = etag;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_vld = 1'b0; op = 2'b00; opa = '0; opb = '0; flip_mask = '0;
    repeat (3) @(negedge clk);
    check(chk_vld === 1'b0, "R9", {63'b0, chk_vld}, 64'b0);
    check(chk_err === 1'b0, "R9", {63'b0, chk_err}, 64'b0);
    rst_n = 1'b1;

    // directed corners
    apply(1, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0, "R6");
    apply(1, 2'b01, 32'h0, 32'h1, 64'h0, "R6");
    apply(1, 2'b01, 32'h5, 32'h5, 64'h0, "R6");
    apply(1, 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0, "R6");
    apply(1, 2'b00, 32'd10, 32'd20, 64'h1, "R7");
    apply(1, 2'b01, 32'h0, 32'h7, 64'h8000_0000_0000_0000, "R7");
    apply(1, 2'b10, 32'h1234_5678, 32'h9ABC_DEF0, 64'h0000_0100_0000_0000, "R7");
    apply(1, 2'b00, 32'd4, 32'd0, 64'h3, "R10");
    apply(1, 2'b11, 32'd9, 32'd9, 64'h5, "R4");
    apply(0, 2'b00, 32'd1, 32'd1, 64'h1, "R8");
    apply(1, 2'b01, 32'h8000_0000, 32'hFFFF_FFFF, 64'hF0F0, "R6");

    // random stream
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  o;
      logic [31:0] a, b;
      logic [63:0] m;
      int          kind;
      string       t;
      bit          v;
      o = 2'($urandom % 4);
      a = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
      b = ($urandom % 8 == 0) ? 32'h0 : $urandom;
      kind = $urandom % 5;
      if (kind < 3)       begin m = 64'h0;                       t = "R6"; end
      else if (kind == 3) begin m = 64'h1 << ($urandom % 64);    t = "R7"; end
      else                begin m = {$urandom, $urandom};        t = "R6"; end
      if (o == 2'b11) t = "R4";
      v = ($urandom % 5) != 0;
      apply(v, o, a, b, m, t);
    end
    apply(0, 2'b00, 32'h0, 32'h0, 64'h0, "R8");
    apply(0, 2'b00, 32'h0, 32'h0, 64'h0, "R8");

    done = 1;
    summary();
    $finish;
  end

endmodule